// File: doc/BRIEF.md
# Gigabit Ethernet Idle Character Rewriter

This block sits in the transmit path of a Gigabit Ethernet PCS, one stage ahead of the 8B/10B encoder. It takes one byte and one control flag per cycle of a 125 MHz clock. It watches for the K28.5 comma and may rewrite the byte that comes right after it. When that byte is an ordinary data character, the block replaces it with the idle data character that leaves the line at negative running disparity once the ordered set ends. Two encodings are possible. A positive disparity before the comma gives D5.6, which flips the disparity. A negative disparity gives D16.2, which keeps it.

The downstream encoder supplies the running disparity as an input. The block samples that input in the cycle the comma is on the bus. Configuration ordered sets (D21.5 or D2.2 after the comma) and control characters pass through untouched. Every byte leaves the block exactly one cycle after it enters. The control flag is carried alongside the byte unchanged.

Character codes use the usual byte layout: Dx.y or Kx.y is the byte `{y[2:0], x[4:0]}`.

Top module: `gige_idle_rewriter`

## Requirements
- R1: Each output byte and output K flag appear one clock after the matching input. The K flag is never altered. A byte not rewritten by R2 or R3 is copied unchanged.
- R2: A byte is rewritten to D5.6 (0xC5) when all of the following hold: it has K=0, it directly follows a comma (K=1, byte 0xBC), and the disparity input was 1 (positive) in the comma's cycle.
- R3: Under the same conditions but with a disparity input of 0 (negative) in the comma's cycle, the byte is rewritten to D16.2 (0x50).
- R4: Only the disparity input value present in the comma's cycle decides the choice in R2/R3. Its value in the following cycle has no effect.
- R5: D21.5 (0xB5, K=0) and D2.2 (0x42, K=0) that directly follow a comma are passed through unchanged.
- R6: A control character (K=1) that directly follows a comma is passed through unchanged.
- R7: A comma that directly follows a comma is passed through unchanged and starts a new ordered set. The byte after it is judged with the disparity sampled with the second comma.
- R8: While rst_n (synchronous, active low) is low at a clock edge, the output after that edge is byte 0x00 with K=0. The first byte accepted after reset is never rewritten.
- R9: Only byte 0xBC with K=1 counts as a comma. Byte 0xBC with K=0 (D28.5) does not arm a rewrite of the next byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Byte from the MAC side |
| in_k | input | 1 | 1 when in_data is a control character |
| rd_pos | input | 1 | Current running disparity from the encoder, 1 = positive |
| out_data | output | 8 | Byte to the encoder, possibly rewritten |
| out_k | output | 1 | Control flag to the encoder, delayed copy of in_k |

## Verification
The bench changes the disparity input in the cycle after a comma. A design that sampled it late would choose the wrong idle character. It puts commas back to back, where a design that rewrote the second comma would emit a data byte with K set. It also checks that the second comma's disparity, not the first's, picks the next character. Both configuration codes, a control character after a comma and a D28.5 data byte appear, so a missing exception or a comma match that ignores the K flag shows up as a rewritten byte. A comma held in the last reset cycle checks that reset clears the pending rewrite.

// File: rtl/gige_idle_pkg.sv
// Shared widths, character codes and types for the idle rewriter.
// Assumes the byte layout {y[2:0], x[4:0]} for a Dx.y / Kx.y character.
package gige_idle_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned X_W    = 5;
    localparam int unsigned Y_W    = BYTE_W - X_W;

    typedef logic [BYTE_W-1:0] byte_t;

    // Build the byte for character x.y
    function automatic byte_t char_code(input logic [X_W-1:0] x, input logic [Y_W-1:0] y);
        return {y, x};
    endfunction

    localparam byte_t COMMA_CODE = char_code(5'd28, 3'd5); // K28.5 with K=1
    localparam byte_t IDLE_FLIP  = char_code(5'd5,  3'd6); // D5.6, disparity flips
    localparam byte_t IDLE_KEEP  = char_code(5'd16, 3'd2); // D16.2, disparity kept
    localparam byte_t CFG_ONE    = char_code(5'd21, 3'd5); // D21.5
    localparam byte_t CFG_TWO    = char_code(5'd2,  3'd2); // D2.2

    // State remembered from the previous byte slot
    typedef struct packed {
        logic armed;   // previous byte was a comma
        logic rd_pos;  // disparity captured with that byte
    } comma_ctx_t;

endpackage

// File: rtl/idle_comma_track.sv
// Remembers whether the byte of the current cycle is a comma and the
// disparity present with it, for use in the next cycle.
// Assumes rd_pos is valid every cycle; it is only used after a comma.
module idle_comma_track
    import gige_idle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  byte_t      in_data,
    input  logic       in_k,
    input  logic       rd_pos,
    output comma_ctx_t ctx
);

    logic is_comma;

    // Comma match needs both the K flag and the K28.5 code
    always_comb begin
        is_comma = in_k && (in_data == COMMA_CODE);
    end

    // Store comma flag and disparity of this slot; reset disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx <= '0;
        end else begin
            ctx.armed  <= is_comma;
            ctx.rd_pos <= rd_pos;
        end
    end

endmodule

// File: rtl/idle_char_select.sv
// Chooses the byte to send: the idle replacement when the previous byte
// was a comma and this one is a non-exempt data byte, else the input.
// Purely combinational; assumes ctx comes from idle_comma_track.
module idle_char_select
    import gige_idle_pkg::*;
(
    input  comma_ctx_t ctx,
    input  byte_t      in_data,
    input  logic       in_k,
    output byte_t      sel_data
);

    logic exempt;
    logic rewrite;

    // Configuration codes and control characters are left alone
    always_comb begin
        exempt  = (in_data == CFG_ONE) || (in_data == CFG_TWO);
        rewrite = ctx.armed && !in_k && !exempt;
    end

    // Positive disparity takes the flipping idle, negative the keeping one
    always_comb begin
        if (rewrite) begin
            sel_data = ctx.rd_pos ? IDLE_FLIP : IDLE_KEEP;
        end else begin
            sel_data = in_data;
        end
    end

endmodule

// File: rtl/gige_idle_rewriter.sv
// Top of the idle rewriter: comma tracking, character selection and one
// output register, for a fixed latency of one cycle.
// Assumes synchronous active-low reset and a byte every cycle.
module gige_idle_rewriter
    import gige_idle_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_k,
    input  logic              rd_pos,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_k
);

    comma_ctx_t ctx;
    byte_t      sel_data;

    idle_comma_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_data (in_data),
        .in_k    (in_k),
        .rd_pos  (rd_pos),
        .ctx     (ctx)
    );

    idle_char_select u_select (
        .ctx      (ctx),
        .in_data  (in_data),
        .in_k     (in_k),
        .sel_data (sel_data)
    );

    // Register the chosen byte and the untouched K flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_k    <= 1'b0;
        end else begin
            out_data <= sel_data;
            out_k    <= in_k;
        end
    end

endmodule

// File: rtl/gige_idle_rewriter_chk.sv
// Property checker for gige_idle_rewriter, attached through bind.
// Keeps its own two-slot history of the inputs to relate them to outputs.
module gige_idle_rewriter_chk
    import gige_idle_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  in_data,
    input logic        in_k,
    input logic        rd_pos,
    input logic [7:0]  out_data,
    input logic        out_k
);

    logic       seen = 1'b0;
    logic       r1   = 1'b0;
    logic       r2   = 1'b0;
    logic [7:0] p1_data = '0;
    logic       p1_k    = 1'b0;
    logic [7:0] p2_data = '0;
    logic       p2_k    = 1'b0;
    logic       p2_rd   = 1'b0;
    logic       p1_rd   = 1'b0;

    // Input history and reset history, one and two slots back
    always @(posedge clk) begin
        seen    <= 1'b1;
        r1      <= rst_n;
        r2      <= r1;
        p1_data <= in_data;
        p1_k    <= in_k;
        p1_rd   <= rd_pos;
        p2_data <= p1_data;
        p2_k    <= p1_k;
        p2_rd   <= p1_rd;
    end

    logic comma2;
    logic exempt1;
    always_comb begin
        comma2  = r2 && p2_k && (p2_data == COMMA_CODE);
        exempt1 = (p1_data == CFG_ONE) || (p1_data == CFG_TWO);
    end

    a_r1_k_follows: assert property (@(posedge clk) disable iff (!rst_n)
        r1 |-> out_k == p1_k);

    a_r1_plain_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (r1 && !comma2) |-> out_data == p1_data);

    a_r2_flip_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (r1 && comma2 && p2_rd && !p1_k && !exempt1) |-> out_data == IDLE_FLIP);

    a_r3_keep_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (r1 && comma2 && !p2_rd && !p1_k && !exempt1) |-> out_data == IDLE_KEEP);

    a_r5_cfg_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (r1 && comma2 && !p1_k && exempt1) |-> out_data == p1_data);

    a_r6_ctrl_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (r1 && p1_k) |-> (out_data == p1_data && out_k));

    a_r8_reset_out: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !r1) |-> (out_data == 8'h00 && !out_k));

endmodule

bind gige_idle_rewriter gige_idle_rewriter_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_k     (in_k),
    .rd_pos   (rd_pos),
    .out_data (out_data),
    .out_k    (out_k)
);

// File: tb/test_gige_idle_rewriter.sv
// Directed bench: one task per scenario, each checking its own outputs.
module test_gige_idle_rewriter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_k = 1'b0;
    logic       rd_pos = 1'b0;
    logic [7:0] out_data;
    logic       out_k;

    int total = 0;
    int bad   = 0;

    localparam logic [7:0] K285 = 8'hBC;
    localparam logic [7:0] D56  = 8'hC5;
    localparam logic [7:0] D162 = 8'h50;
    localparam logic [7:0] D215 = 8'hB5;
    localparam logic [7:0] D22  = 8'h42;
    localparam logic [7:0] D143 = 8'h6E;
    localparam logic [7:0] D240 = 8'h18;
    localparam logic [7:0] K281 = 8'h3C;

    gige_idle_rewriter i_gige_idle_rewriter (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_k     (in_k),
        .rd_pos   (rd_pos),
        .out_data (out_data),
        .out_k    (out_k)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] ed, input logic ek);
        total++;
        if (out_data !== ed || out_k !== ek) begin
            bad++;
            $display("FAIL %s: got data=%02h k=%0b, expected data=%02h k=%0b",
                     tag, out_data, out_k, ed, ek);
        end
    endtask

    // Drive one byte at a falling edge, then check its output one cycle on
    task automatic step(input logic [7:0] d, input logic k, input logic rd,
                        input logic [7:0] ed, input logic ek, input string tag);
        in_data = d;
        in_k    = k;
        rd_pos  = rd;
        @(negedge clk);
        check(tag, ed, ek);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(K285, 1'b1, 1'b1, 8'h00, 1'b0, "R8 reset output");
        step(K285, 1'b1, 1'b1, 8'h00, 1'b0, "R8 reset output comma held");
        rst_n = 1'b1;
        step(D143, 1'b0, 1'b1, D143, 1'b0, "R8 first byte not rewritten");
    endtask

    task automatic t_idle_pos;
        step(K285, 1'b1, 1'b1, K285, 1'b1, "R1 comma copied");
        step(D143, 1'b0, 1'b1, D56, 1'b0, "R2 D14.3 to D5.6");
        step(K285, 1'b1, 1'b1, K285, 1'b1, "R1 comma copied");
        step(D240, 1'b0, 1'b1, D56, 1'b0, "R2 D24.0 to D5.6");
    endtask

    task automatic t_idle_neg;
        step(K285, 1'b1, 1'b0, K285, 1'b1, "R1 comma copied");
        step(D240, 1'b0, 1'b0, D162, 1'b0, "R3 D24.0 to D16.2");
        step(K285, 1'b1, 1'b0, K285, 1'b1, "R1 comma copied");
        step(D56,  1'b0, 1'b0, D162, 1'b0, "R3 D5.6 to D16.2");
    endtask

    task automatic t_rd_timing;
        step(K285, 1'b1, 1'b1, K285, 1'b1, "R4 comma");
        step(D143, 1'b0, 1'b0, D56, 1'b0, "R4 late rd ignored, pos");
        step(K285, 1'b1, 1'b0, K285, 1'b1, "R4 comma");
        step(D143, 1'b0, 1'b1, D162, 1'b0, "R4 late rd ignored, neg");
    endtask

    task automatic t_config;
        step(K285, 1'b1, 1'b1, K285, 1'b1, "R5 comma");
        step(D215, 1'b0, 1'b1, D215, 1'b0, "R5 D21.5 kept");
        step(K285, 1'b1, 1'b0, K285, 1'b1, "R5 comma");
        step(D22,  1'b0, 1'b0, D22, 1'b0, "R5 D2.2 kept");
    endtask

    task automatic t_ctrl;
        step(K285, 1'b1, 1'b1, K285, 1'b1, "R6 comma");
        step(K281, 1'b1, 1'b1, K281, 1'b1, "R6 K28.1 kept");
        step(D143, 1'b0, 1'b1, D143, 1'b0, "R1 byte after K28.1 copied");
    endtask

    task automatic t_double_comma;
        step(K285, 1'b1, 1'b0, K285, 1'b1, "R7 first comma");
        step(K285, 1'b1, 1'b1, K285, 1'b1, "R7 second comma kept");
        step(D240, 1'b0, 1'b0, D56, 1'b0, "R7 rd of second comma used");
    endtask

    task automatic t_not_comma;
        step(D143, 1'b0, 1'b1, D143, 1'b0, "R1 plain data copied");
        step(K285, 1'b0, 1'b1, K285, 1'b0, "R9 D28.5 copied");
        step(D240, 1'b0, 1'b1, D240, 1'b0, "R9 no rewrite after D28.5");
    endtask

    // Watchdog: a hung run counts as one failure
    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_pos();
        t_idle_neg();
        t_rd_timing();
        t_config();
        t_ctrl();
        t_double_comma();
        t_not_comma();
        t_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule